// File: doc/BRIEF.md
# Deferred Floating-Point Error Flag

This block produces the active-high error output that a processor core uses to tell system logic about an unmasked floating-point exception. The output does not rise when the faulting instruction retires. The block records the fault as a pending condition. It raises the output only when a later floating-point arithmetic instruction or WAIT instruction reaches its instruction boundary.

The output is lowered in three cases. The first is completion of a clearing instruction: clear-exceptions, initialize, save-state or store-environment. The second is completion of a load instruction (control-word load, environment load or state restore) whose newly loaded status and control words no longer show an unmasked exception. The third is reset.

The numeric-error enable bit of the control register and the ignore-numeric-error input are accepted but have no effect. A test-mode input turns the output enable off so that the pad can float. Exception detection, instruction decode and the pad driver itself are outside the block.

Top module: `fp_error_flag`

## Requirements
- R1: A pulse on `exc_valid` sets the pending condition but does not raise `err_out`. This holds even when a class-1 or class-2 boundary strobe arrives in the same cycle.
- R2: A boundary strobe whose class is 1 (floating-point arithmetic) or 2 (WAIT) raises `err_out` on the next clock edge if the condition was pending before that cycle. Once raised, `err_out` stays high until something clears it.
- R3: A boundary strobe of class 0, or of the unused codes 5, 6 and 7, never raises `err_out`. A class code presented with `bnd_valid` low has no effect.
- R4: `nerr_enable` has no effect on `err_out`.
- R5: `ign_err` has no effect on `err_out`.
- R6: A class-3 strobe (clearing group) clears the pending condition and lowers `err_out` on the next edge.
- R7: A class-4 strobe (load group) replaces the pending condition with `ld_status[7] & |(ld_status[5:0] & ~ld_control[5:0])`. Bits 5:0 of the status word are the exception flags and bit 7 is the error summary. Bits 5:0 of the control word are the masks, where 1 means masked. If the new condition is false, `err_out` is lowered on the next edge. If it is true, `err_out` keeps its value.
- R8: If `exc_valid` and a class-3 strobe occur in the same cycle, `err_out` is lowered but the pending condition stays set. A later class-1 or class-2 boundary then raises `err_out` again.
- R9: While `rst_n` is low at a clock edge, `err_out` and the pending condition are cleared.
- R10: `err_oe` is the inverse of `test_tristate`. The test mode does not change `err_out` or the pending condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid | input | 1 | A floating-point instruction retired with an unmasked exception |
| bnd_valid | input | 1 | One-cycle instruction-boundary strobe |
| bnd_class | input | 3 | Class of the instruction at the boundary (0 other, 1 FP arithmetic, 2 WAIT, 3 clearing, 4 load) |
| ld_status | input | 16 | Status word produced by a load-group instruction |
| ld_control | input | 16 | Control word produced by a load-group instruction |
| nerr_enable | input | 1 | Numeric-error enable bit of the control register (unused) |
| ign_err | input | 1 | Ignore-numeric-error input (unused) |
| test_tristate | input | 1 | Tri-state test mode |
| err_out | output | 1 | Registered floating-point error output |
| err_oe | output | 1 | Output enable for the error pad |

## Verification
The assertions take for granted that a boundary strobe lasts exactly one cycle and carries a settled class code. They also assume that the load-group buses are meaningful in the strobe cycle. Beyond those points they allow any overlap of exceptions with boundaries of every class. The stimulus drives every input half a cycle away from the sampling edge. It combines directed overlaps (an exception arriving with its own boundary, and an exception arriving with a clearing instruction) with a long run of random classes, including the unused codes and random status and control words.

// File: rtl/fperr_pkg.sv
// Package fperr_pkg
// Shared class codes and status/control field positions for the deferred
// floating-point error flag. Assumes the 3-bit class encoding below.
package fperr_pkg;
    localparam int CLS_W   = 3;
    localparam int WORD_W  = 16;
    localparam int EXC_N   = 6;
    localparam int SUM_POS = 7;

    typedef enum logic [CLS_W-1:0] {
        CLS_OTHER = 3'd0,
        CLS_ARITH = 3'd1,
        CLS_WAIT  = 3'd2,
        CLS_CLEAR = 3'd3,
        CLS_LOAD  = 3'd4
    } ins_class_e;
endpackage

// File: rtl/fperr_decode.sv
// Module fperr_decode
// Turns a qualified boundary strobe into the three requests the flag logic
// needs. Assumes bnd_valid lasts exactly one cycle per instruction. Unused
// class codes decode to no request.
module fperr_decode
    import fperr_pkg::*;
#(
    parameter int CW = CLS_W
) (
    input  logic          bnd_valid,
    input  logic [CW-1:0] bnd_class,
    output logic          raise_req,
    output logic          clear_req,
    output logic          load_req
);
    // Decode the class of the instruction at the boundary.
    always_comb begin
        raise_req = 1'b0;
        clear_req = 1'b0;
        load_req  = 1'b0;
        if (bnd_valid) begin
            case (bnd_class)
                CW'(CLS_ARITH),
                CW'(CLS_WAIT):  raise_req = 1'b1;
                CW'(CLS_CLEAR): clear_req = 1'b1;
                CW'(CLS_LOAD):  load_req  = 1'b1;
                default:        ;
            endcase
        end
    end
endmodule

// File: rtl/fperr_loadcond.sv
// Module fperr_loadcond
// Recomputes the pending condition from freshly loaded status and control
// words: the summary bit AND any exception flag whose mask bit is clear.
// Assumes a mask bit of 1 means the exception is masked.
module fperr_loadcond #(
    parameter int W    = fperr_pkg::WORD_W,
    parameter int NEXC = fperr_pkg::EXC_N,
    parameter int SPOS = fperr_pkg::SUM_POS
) (
    input  logic [W-1:0] status_word,
    input  logic [W-1:0] control_word,
    output logic         pend_next
);
    logic [NEXC-1:0] live;
    logic            unused_bits;

    // One unmasked-and-flagged term per exception kind.
    for (genvar i = 0; i < NEXC; i++) begin : g_live
        assign live[i] = status_word[i] & ~control_word[i];
    end

    // Condition holds only while the error summary is set.
    assign pend_next   = status_word[SPOS] & (|live);
    assign unused_bits = &{1'b0, status_word, control_word};
endmodule

// File: rtl/fperr_state.sv
// Module fperr_state
// Holds the pending condition and the registered error output. An exception
// only marks the condition as pending. A raise request turns the output on
// only when the condition was already pending. Clear and load requests lower
// it, and a new exception wins over a clear arriving in the same cycle.
module fperr_state (
    input  logic clk,
    input  logic rst_n,
    input  logic exc_valid,
    input  logic raise_req,
    input  logic clear_req,
    input  logic load_req,
    input  logic load_pend,
    output logic err_q
);
    logic pend_q, pend_d, err_d;

    // Next-state rules for the pending condition and the output.
    always_comb begin
        pend_d = pend_q;
        err_d  = err_q;
        if (raise_req && pend_q) err_d = 1'b1;
        if (clear_req) begin
            pend_d = 1'b0;
            err_d  = 1'b0;
        end
        if (load_req) begin
            pend_d = load_pend;
            if (!load_pend) err_d = 1'b0;
        end
        if (exc_valid) pend_d = 1'b1;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            err_q  <= err_d;
        end
    end

    // R1
    exc_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !pend_q) |=> !err_q);
    // R2
    raise_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_req && pend_q && !clear_req) |=> err_q);
    // R2
    out_implies_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> pend_q);
    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !exc_valid) |=> (!err_q && !pend_q));
    // R7
    load_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !load_pend) |=> !err_q);
    // R8
    exc_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && exc_valid) |=> (pend_q && !err_q));
    // R9
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!err_q && !pend_q));
endmodule

// File: rtl/fp_error_flag.sv
// Module fp_error_flag
// Top level of the deferred floating-point error flag. It connects the
// boundary decoder, the load-condition recompute and the state registers.
// The output enable is turned off in tri-state test mode. The numeric-error
// enable and ignore inputs are accepted and deliberately left without effect.
module fp_error_flag
    import fperr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic              bnd_valid,
    input  logic [CLS_W-1:0]  bnd_class,
    input  logic [WORD_W-1:0] ld_status,
    input  logic [WORD_W-1:0] ld_control,
    input  logic              nerr_enable,
    input  logic              ign_err,
    input  logic              test_tristate,
    output logic              err_out,
    output logic              err_oe
);
    logic raise_req, clear_req, load_req, load_pend;
    logic unused_in;

    fperr_decode #(.CW(CLS_W)) u_decode (
        .bnd_valid (bnd_valid),
        .bnd_class (bnd_class),
        .raise_req (raise_req),
        .clear_req (clear_req),
        .load_req  (load_req)
    );

    fperr_loadcond #(.W(WORD_W), .NEXC(EXC_N), .SPOS(SUM_POS)) u_loadcond (
        .status_word  (ld_status),
        .control_word (ld_control),
        .pend_next    (load_pend)
    );

    fperr_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_valid (exc_valid),
        .raise_req (raise_req),
        .clear_req (clear_req),
        .load_req  (load_req),
        .load_pend (load_pend),
        .err_q     (err_out)
    );

    // Pad enable: off only in tri-state test mode.
    assign err_oe    = ~test_tristate;
    assign unused_in = &{1'b0, nerr_enable, ign_err};
endmodule

// File: tb/test_fp_error_flag.sv
// Bench for fp_error_flag. A behavioural reference model is advanced on
// every rising edge and compared with the outputs on every falling edge.
module test_fp_error_flag;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic        bnd_valid = 1'b0;
    logic [2:0]  bnd_class = 3'd0;
    logic [15:0] ld_status = 16'h0;
    logic [15:0] ld_control = 16'h0;
    logic        nerr_enable = 1'b0;
    logic        ign_err = 1'b0;
    logic        test_tristate = 1'b0;
    wire         err_out, err_oe;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R9";
    bit    m_pend = 1'b0;
    bit    m_err = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fp_error_flag i_fp_error_flag (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .bnd_valid(bnd_valid),
        .bnd_class(bnd_class), .ld_status(ld_status), .ld_control(ld_control),
        .nerr_enable(nerr_enable), .ign_err(ign_err),
        .test_tristate(test_tristate), .err_out(err_out), .err_oe(err_oe)
    );

    // Reference model written from the requirements.
    function automatic bit load_cond(input logic [15:0] s, input logic [15:0] c);
        int n = 0;
        for (int i = 0; i < 6; i++) if (s[i] && !c[i]) n++;
        return s[7] && (n > 0);
    endfunction

    always @(posedge clk) begin
        bit np, ne, lp;
        if (!rst_n) begin
            m_pend = 1'b0;
            m_err  = 1'b0;
        end else begin
            np = m_pend;
            ne = m_err;
            if (bnd_valid && (bnd_class == 3'd1 || bnd_class == 3'd2) && m_pend) ne = 1'b1;
            if (bnd_valid && bnd_class == 3'd3) begin
                np = 1'b0;
                ne = 1'b0;
            end
            if (bnd_valid && bnd_class == 3'd4) begin
                lp = load_cond(ld_status, ld_control);
                np = lp;
                if (!lp) ne = 1'b0;
            end
            if (exc_valid) np = 1'b1;
            m_pend = np;
            m_err  = ne;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare on every falling edge.
    always @(negedge clk) begin
        check(cur_req, err_out, m_err);
        check("R10", err_oe, !test_tristate);
    end

    // One cycle of stimulus, applied just after the falling edge.
    task automatic cyc(input logic e, input logic v, input logic [2:0] c,
                       input logic [15:0] s = 16'h0, input logic [15:0] k = 16'h0);
        @(negedge clk);
        #1;
        exc_valid  = e;
        bnd_valid  = v;
        bnd_class  = c;
        ld_status  = s;
        ld_control = k;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 3'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cur_req = "R9";
        cyc(1, 1, 3'd1);
        cyc(1, 1, 3'd2);
        idle(2);
        #1 rst_n = 1'b1;
        idle(2);

        // R1: exception alone does not raise
        cur_req = "R1";
        cyc(1, 0, 3'd0);
        idle(3);
        // R3: class 0, unused codes, and an unqualified code
        cur_req = "R3";
        cyc(0, 1, 3'd0);
        cyc(0, 1, 3'd5);
        cyc(0, 1, 3'd6);
        cyc(0, 1, 3'd7);
        cyc(0, 0, 3'd1);
        idle(2);
        // R2: arithmetic boundary raises
        cur_req = "R2";
        cyc(0, 1, 3'd1);
        idle(3);
        // R4 / R5: toggling the ignored inputs
        cur_req = "R4";
        nerr_enable = 1'b1; idle(2); nerr_enable = 1'b0; idle(2);
        cur_req = "R5";
        ign_err = 1'b1; idle(2);
        // R6: clearing instruction
        cur_req = "R6";
        cyc(0, 1, 3'd3);
        idle(2);
        // R5: raising still happens with ignore set
        cur_req = "R5";
        cyc(1, 1, 3'd1);
        idle(1);
        cyc(0, 1, 3'd2);
        idle(2);
        ign_err = 1'b0;
        cyc(0, 1, 3'd3);
        // R1: exception with its own boundary, then WAIT raises (R2)
        cur_req = "R1";
        cyc(1, 1, 3'd1);
        idle(2);
        cur_req = "R2";
        cyc(0, 1, 3'd2);
        idle(2);
        // R7: loads that keep, then drop, the condition
        cur_req = "R7";
        cyc(0, 1, 3'd4, 16'h0081, 16'h003E);
        idle(2);
        cyc(0, 1, 3'd4, 16'h0081, 16'h003F);
        idle(2);
        cyc(0, 1, 3'd4, 16'h00A4, 16'h0000);
        idle(1);
        cyc(0, 1, 3'd2);
        idle(2);
        cyc(0, 1, 3'd4, 16'h0024, 16'h0000);
        idle(2);
        // R8: exception and clear together
        cur_req = "R8";
        cyc(1, 1, 3'd1);
        cyc(0, 1, 3'd1);
        cyc(1, 1, 3'd3);
        idle(2);
        cyc(0, 1, 3'd2);
        idle(2);
        // R10: test mode only changes the enable
        cur_req = "R10";
        test_tristate = 1'b1;
        idle(3);
        cyc(0, 1, 3'd3);
        cyc(1, 0, 3'd0);
        cyc(0, 1, 3'd1);
        idle(2);
        test_tristate = 1'b0;
        idle(1);
        // R9: reset mid-run with the output high
        cur_req = "R9";
        #1 rst_n = 1'b0;
        idle(2);
        #1 rst_n = 1'b1;
        idle(2);
        // Random mix of all classes and words
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            nerr_enable   = 1'($urandom_range(0, 1));
            ign_err       = 1'($urandom_range(0, 1));
            test_tristate = ($urandom_range(0, 15) == 0);
            cyc(($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)),
                3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom));
        end
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule